// File: doc/BRIEF.md
# Ratio-Locked Wide Word Bridge

This block carries a 384-bit word from a fast clock domain running at six times a shared frame reference into a slow domain running at four times the same reference. The two clocks share that reference, so their edges line up again at every frame boundary, and the closest fast-to-slow edge separation (about 2.08 ns at 240/160 MHz) is an ordinary single-cycle timing path. No synchronizer, handshake or asynchronous FIFO is needed. The crossing is a fast-side holding register and a slow-side capture register, each gated by a free-running frame-phase counter.

A producer raises `load_req` with a word on the first fast edge of a frame. The holding register keeps that word unchanged for the whole frame. The slow side samples it at slow phase 2, which falls in the middle of the stable window and well away from the next reload. The slow side then presents the word with a one-cycle `out_valid` strobe. A request on any other fast phase would exceed one word per frame. That request is discarded and recorded in a sticky overflow flag.

Both counters clear under one reset. The reset must be released just before a fast edge and a slow edge that coincide at a frame boundary.

Top module: `ratio_word_bridge`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `overflow` are 0 and `out_word` is all zeros.
- R2: A word presented with `load_req` high on the first fast edge of a frame (fast phase 0) appears on `out_word` after slow edge index 2 of that same frame. The slow edge at the frame boundary counts as index 0.
- R3: `out_valid` is high for exactly one slow cycle, after slow edge index 2, in each frame that loaded a word. It is low in the other three slow cycles and for the whole of any frame with no load.
- R4: `out_word` keeps its value between captures.
- R5: `load_req` high on fast phases 1 to 5 loads nothing and does not alter the word transferred in that frame. From the next fast edge onward it drives `overflow` to 1.
- R6: Once set, `overflow` stays at 1 until reset.
- R7: The fast phase counter runs 0 to 5 and the slow phase counter runs 0 to 3. Both read 0 at the first edges after reset release, so at each slow capture edge the fast side is at phase 3.
- R8: Loaded words come out in load order, each exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock, six edges per frame |
| clk_slow | input | 1 | Slow clock, four edges per frame, phase-locked to clk_fast |
| rst_n | input | 1 | Active-low shared frame reset, released before a common frame edge |
| load_req | input | 1 | Fast domain: new word offered this edge |
| load_word | input | 384 | Fast domain: word offered with load_req |
| overflow | output | 1 | Fast domain: sticky flag for an off-phase request |
| out_word | output | 384 | Slow domain: last captured word |
| out_valid | output | 1 | Slow domain: one-cycle strobe with a new word |

## Verification
On every cycle, the embedded properties check four things. The held word does not move mid-frame. The strobe appears only after the capture phase. The output word changes only at a capture edge. The overflow flag sets on an off-phase request and never clears. A further property checks the phase alignment between the two counters at every capture edge. Only the bench scenarios can show end-to-end results: each word arrives intact, exactly once and in order, frames with no load stay silent, and an off-phase request leaves the surrounding traffic undisturbed. These depend on what the producer offered, which no local property knows.

// File: rtl/ratio_word_bridge.sv
module ratio_word_bridge #(
  parameter int WIDTH          = 384,
  parameter int FAST_PER_FRAME = 6,
  parameter int SLOW_PER_FRAME = 4,
  parameter int CAPTURE_PHASE  = 2
) (
  input  logic             clk_fast,
  input  logic             clk_slow,
  input  logic             rst_n,
  input  logic             load_req,
  input  logic [WIDTH-1:0] load_word,
  output logic             overflow,
  output logic [WIDTH-1:0] out_word,
  output logic             out_valid
);
  localparam int FW = $clog2(FAST_PER_FRAME);
  localparam int SW = $clog2(SLOW_PER_FRAME);
  localparam logic [FW-1:0] FAST_LAST = FW'(FAST_PER_FRAME - 1);
  localparam logic [SW-1:0] SLOW_LAST = SW'(SLOW_PER_FRAME - 1);
  localparam logic [SW-1:0] CAP_PH    = SW'(CAPTURE_PHASE);
  localparam logic [FW-1:0] FAST_AT_CAP = FW'(CAPTURE_PHASE * FAST_PER_FRAME / SLOW_PER_FRAME);

  logic [FW-1:0]    ph_f;
  logic [SW-1:0]    ph_s;
  logic [WIDTH-1:0] held;
  logic             fresh;

  wire frame_start = (ph_f == '0);
  wire capture     = (ph_s == CAP_PH);

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      ph_f     <= '0;
      held     <= '0;
      fresh    <= 1'b0;
      overflow <= 1'b0;
    end else begin
      ph_f <= (ph_f == FAST_LAST) ? '0 : ph_f + 1'b1;
      if (frame_start) begin
        fresh <= load_req;
        if (load_req) held <= load_word;
      end
      if (load_req && !frame_start) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk_slow or negedge rst_n) begin
    if (!rst_n) begin
      ph_s      <= '0;
      out_word  <= '0;
      out_valid <= 1'b0;
    end else begin
      ph_s      <= (ph_s == SLOW_LAST) ? '0 : ph_s + 1'b1;
      out_valid <= capture && fresh;
      if (capture && fresh) out_word <= held;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !frame_start |=> $stable(held)); // R5
  AST_OVF_SET: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (load_req && !frame_start) |=> overflow); // R5
  AST_OVF_STICKY: assert property (@(posedge clk_fast) disable iff (!rst_n)
    overflow |=> overflow); // R6
  AST_FAST_RANGE: assert property (@(posedge clk_fast) disable iff (!rst_n)
    ph_f <= FAST_LAST); // R7
  AST_VALID_PHASE: assert property (@(posedge clk_slow) disable iff (!rst_n)
    !capture |=> !out_valid); // R3
  AST_WORD_HOLD: assert property (@(posedge clk_slow) disable iff (!rst_n)
    !(capture && fresh) |=> $stable(out_word)); // R4
  AST_PHASE_LOCK: assert property (@(posedge clk_slow) disable iff (!rst_n)
    capture |-> ph_f == FAST_AT_CAP); // R7
endmodule

// File: tb/ratio_word_bridge_bench.sv
`timescale 1ns/1ps
module ratio_word_bridge_bench;
  localparam int W  = 384;
  localparam int NF = 44;

  logic clk_fast = 1'b0, clk_slow = 1'b0, rst_n = 1'b0, load_req = 1'b0;
  logic [W-1:0] load_word = '0;
  logic overflow, out_valid;
  logic [W-1:0] out_word;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [W-1:0] exp_word [NF];
  bit exp_load [NF];

  ratio_word_bridge u_ratio_word_bridge (
    .clk_fast(clk_fast), .clk_slow(clk_slow), .rst_n(rst_n),
    .load_req(load_req), .load_word(load_word),
    .overflow(overflow), .out_word(out_word), .out_valid(out_valid));

  // Fast rises at 3,7,11,...; slow at 3,9,15,...; common frame edge every 24 ns from 51.
  initial begin #1; forever #2 clk_fast = ~clk_fast; end
  initial forever #3 clk_slow = ~clk_slow;

  function automatic logic [W-1:0] rand_word();
    logic [W-1:0] w;
    for (int i = 0; i < W/32; i++) w[i*32 +: 32] = $urandom;
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    void'($urandom(32'd9137));
    for (int f = 0; f < NF; f++) begin exp_load[f] = 1'b0; exp_word[f] = '0; end
    #20;
    check(out_valid === 1'b0, "R1", "valid in reset", W'(out_valid), '0);
    check(overflow === 1'b0, "R1", "overflow in reset", W'(overflow), '0);
    check(out_word === '0, "R1", "word in reset", out_word, '0);
    #30 rst_n = 1'b1;
    for (int f = 0; f < NF; f++) begin
      for (int p = 0; p < 6; p++) begin
        bit lr;
        logic [W-1:0] w;
        w  = rand_word();
        lr = 1'b0;
        if (p == 0) begin
          if (f < 40) lr = (f == 1) ? 1'b0 : (f < 4) ? 1'b1 : ($urandom % 4 != 0);
          else if (f > 40) lr = 1'b1;
          if (lr) begin exp_load[f] = 1'b1; exp_word[f] = w; end
        end else if ((f == 40 && p == 3) || (f == 42 && p == 4)) begin
          lr = 1'b1; // off-phase request, R5
        end
        load_req  = lr;
        load_word = w;
        @(posedge clk_fast); #1;
      end
      if (f == 39) check(overflow === 1'b0, "R5", "overflow before off-phase", W'(overflow), '0);
      if (f == 40) check(overflow === 1'b1, "R5", "overflow after off-phase", W'(overflow), W'(1));
      if (f == NF-1) check(overflow === 1'b1, "R6", "overflow sticky", W'(overflow), W'(1));
    end
    load_req = 1'b0;
    #48 done = 1'b1;
  end

  // Slow monitor: edge k after release; capture result visible after k%4==2 (R2, R7).
  initial begin
    logic [W-1:0] last;
    int k;
    last = '0;
    k = 0;
    @(posedge rst_n);
    forever begin
      @(posedge clk_slow); #1;
      if (k / 4 < NF) begin
        if (k % 4 == 2) begin
          check(out_valid === exp_load[k/4], "R3", "strobe at capture", W'(out_valid), W'(exp_load[k/4]));
          if (exp_load[k/4]) begin
            check(out_word === exp_word[k/4], "R2", "captured word (R8 order)", out_word, exp_word[k/4]);
            last = exp_word[k/4];
          end else begin
            check(out_word === last, "R4", "word held, no load (R5 off-phase)", out_word, last);
          end
        end else begin
          check(out_valid === 1'b0, "R3", "strobe off-phase", W'(out_valid), '0);
          check(out_word === last, "R4", "word held", out_word, last);
        end
      end
      k++;
    end
  end

  initial begin
    wait (done);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule